// File: doc/BRIEF.md
# Dual-channel programmable interval timer

This block holds two independent 16-bit down-counters, called channel 0 and channel 2, behind a byte-wide write port. A built-in rate generator turns the system clock into an enable pulse at a fixed counting rate of 1,193,180 Hz on average. One count lasts one period of that rate. Software first writes a control byte that names a channel and stores its operating mode. It then writes the count to that channel's data address as two bytes, low byte first. The channel begins counting only when the high byte arrives.

When a channel reaches terminal count it raises a one-cycle interrupt pulse, marks itself as fired and reloads its programmed count. This gives a periodic rate generator. A status read for a channel returns 0x20 once it has fired and 0x00 before that. The block accepts only the low-then-high byte access mode. A control byte that asks for any other access mode, or for the unsupported read-back command, pulses an error output and changes nothing.

Top module: `ivl_timer`

## Requirements
- R1: Counts advance at BASE_HZ/CLK_HZ of the clock rate. With k clock edges since reset, floor(k*BASE_HZ/CLK_HZ) count ticks have occurred, and a tick belongs to edge k when that value steps up there.
- R2: Writing the control byte goes to address 3. Bits 7:6 pick the target: 00 is channel 0 and 10 is channel 2. Value 01 is ignored without error. A write to one channel leaves the other channel's stored mode unchanged.
- R3: A control byte with bits 7:6 = 11 (read-back) makes cfg_err high for exactly the cycle after the write. It changes no channel state. cfg_err is low after any cycle that has no control write.
- R4: A control byte to channel 0 or 2 with bits 5:4 other than 11 pulses cfg_err. The target channel's mode and byte phase stay as they were.
- R5: A valid control byte stores its bits 3:1 as the channel's mode. This appears on cnt_mode[2:0] for channel 0 and on cnt_mode[5:3] for channel 2, one cycle after the write.
- R6: Data for channel 0 goes to address 0 and data for channel 2 goes to address 2. The first byte is the low byte and the second is the high byte. A channel that has only received a low byte does not count.
- R7: A valid control byte to a channel resets that channel's byte phase, so the next data byte is taken as the low byte.
- R8: After the high byte loads count N, the first terminal count falls on the N-th tick. It then repeats every N ticks.
- R9: A programmed count of 0 gives a period of 65,536 ticks.
- R10: The status byte on rd_data (rd_sel 0 reads channel 0, 1 reads channel 2) is 0x20 after the channel's first terminal count. It is 0x00 before that, and again after each new count is loaded.
- R11: Each terminal count gives irq[0] (channel 0) or irq[1] (channel 2) high for the one cycle after the terminal tick.
- R12: After reset, irq, cfg_err, cnt_mode and both status bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | Write target: 0 ch0 data, 2 ch2 data, 3 control |
| wr_data | input | 8 | Write byte |
| rd_sel | input | 1 | Status channel select |
| rd_data | output | 8 | Status byte of the selected channel |
| irq | output | 2 | Terminal-count pulses, bit 0 channel 0, bit 1 channel 2 |
| cnt_mode | output | 6 | Stored modes, channel 2 in bits 5:3 |
| cfg_err | output | 1 | Rejected control byte pulse |

## Verification
The properties assume that the write inputs and rd_sel hold known values whenever reset is released. They also assume that at most one byte is written per cycle, which the single write address already guarantees. The bench meets both conditions by changing its inputs only on falling edges and by idling the strobe between writes. A behavioural model tracks every channel's phase, count and fired flag in integers, using tick timing derived from R1. It predicts irq, cfg_err, cnt_mode and the selected status byte each cycle. Directed sequences measure periods in ticks, which covers the short, single-tick and 65,536-tick cases.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
   localparam logic [1:0] ADDR_CH0  = 2'd0;
   localparam logic [1:0] ADDR_CH2  = 2'd2;
   localparam logic [1:0] ADDR_CTRL = 2'd3;

   localparam logic [1:0] SEL_CH0   = 2'b00;
   localparam logic [1:0] SEL_CH1   = 2'b01;
   localparam logic [1:0] SEL_CH2   = 2'b10;
   localparam logic [1:0] SEL_RDBK  = 2'b11;
   localparam logic [1:0] ACC_LOHI  = 2'b11;

   localparam int MODE_W = 3;
   localparam int NUM_CH = 2;
endpackage

// File: rtl/ivl_timer_rate.sv
module ivl_timer_rate #(
   parameter int unsigned CLK_HZ  = 4772720,
   parameter int unsigned BASE_HZ = 1193180
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int ACC_W = $clog2(CLK_HZ) + 1;
   localparam int SUM_W = ACC_W + 1;
   localparam logic [SUM_W-1:0] BASE_V = SUM_W'(BASE_HZ);
   localparam logic [SUM_W-1:0] CLK_V  = SUM_W'(CLK_HZ);

   logic [ACC_W-1:0] acc_q;
   logic [SUM_W-1:0] sum;

   always_comb begin
      sum  = {1'b0, acc_q} + BASE_V;
      tick = (sum >= CLK_V);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else if (tick) acc_q <= ACC_W'(sum - CLK_V);
      else acc_q <= ACC_W'(sum);
   end
endmodule

// File: rtl/ivl_timer_chan.sv
module ivl_timer_chan #(
   parameter int DATA_W = 8,
   parameter int MODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              ctrl_wr,
   input  logic [MODE_W-1:0] ctrl_mode,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_byte,
   output logic [MODE_W-1:0] mode_o,
   output logic              fired_o,
   output logic              irq_o
);
   localparam int CNT_W = 2 * DATA_W;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic              hi_next_q;
   logic [DATA_W-1:0] low_q;
   logic [CNT_W-1:0]  reload_q;
   logic [CNT_W-1:0]  count_q;
   logic              run_q;
   logic              load;

   assign load = data_wr && hi_next_q && !ctrl_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_next_q <= 1'b0;
         low_q     <= '0;
         reload_q  <= '0;
         count_q   <= '0;
         run_q     <= 1'b0;
         fired_o   <= 1'b0;
         irq_o     <= 1'b0;
         mode_o    <= '0;
      end else begin
         irq_o <= 1'b0;
         if (ctrl_wr) begin
            mode_o    <= ctrl_mode;
            hi_next_q <= 1'b0;
         end else if (data_wr) begin
            if (!hi_next_q) begin
               low_q     <= data_byte;
               hi_next_q <= 1'b1;
            end else begin
               reload_q  <= {data_byte, low_q};
               count_q   <= {data_byte, low_q};
               run_q     <= 1'b1;
               fired_o   <= 1'b0;
               hi_next_q <= 1'b0;
            end
         end
         if (run_q && tick && !load) begin
            if (count_q == ONE) begin
               count_q <= reload_q;
               fired_o <= 1'b1;
               irq_o   <= 1'b1;
            end else begin
               count_q <= count_q - ONE;
            end
         end
      end
   end
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
   import ivl_timer_pkg::*;
#(
   parameter int unsigned CLK_HZ  = 4772720,
   parameter int unsigned BASE_HZ = 1193180,
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] FIRED_CODE = 8'h20
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [1:0]               wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     rd_sel,
   output logic [DATA_W-1:0]        rd_data,
   output logic [NUM_CH-1:0]        irq,
   output logic [NUM_CH*MODE_W-1:0] cnt_mode,
   output logic                     cfg_err
);
   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("ivl_timer: control byte layout needs DATA_W of 8");
      end
      if (BASE_HZ == 0 || BASE_HZ > CLK_HZ) begin : g_bad_rate
         $error("ivl_timer: BASE_HZ must be nonzero and not above CLK_HZ");
      end
   endgenerate

   logic              tick;
   logic              ctrl_hit;
   logic [1:0]        sel;
   logic              acc_ok;
   logic              reject;
   logic [NUM_CH-1:0] fired;

   ivl_timer_rate #(.CLK_HZ(CLK_HZ), .BASE_HZ(BASE_HZ)) u_rate (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   assign ctrl_hit = wr_en && (wr_addr == ADDR_CTRL);
   assign sel      = wr_data[7:6];
   assign acc_ok   = (wr_data[5:4] == ACC_LOHI);
   assign reject   = ctrl_hit && ((sel == SEL_RDBK) || ((sel != SEL_CH1) && !acc_ok));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_err <= 1'b0;
      else cfg_err <= reject;
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      localparam logic [1:0] MY_SEL  = (g == 0) ? SEL_CH0 : SEL_CH2;
      localparam logic [1:0] MY_ADDR = (g == 0) ? ADDR_CH0 : ADDR_CH2;
      logic ch_ctrl;
      logic ch_data;
      assign ch_ctrl = ctrl_hit && (sel == MY_SEL) && acc_ok;
      assign ch_data = wr_en && (wr_addr == MY_ADDR);

      ivl_timer_chan #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (tick),
         .ctrl_wr  (ch_ctrl),
         .ctrl_mode(wr_data[MODE_W:1]),
         .data_wr  (ch_data),
         .data_byte(wr_data),
         .mode_o   (cnt_mode[g*MODE_W +: MODE_W]),
         .fired_o  (fired[g]),
         .irq_o    (irq[g]));
   end

   assign rd_data = fired[rd_sel] ? FIRED_CODE : '0;
endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk #(
   parameter logic [7:0] FIRED_CODE = 8'h20
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [1:0] wr_addr,
   input logic [7:1] ctl_hi,
   input logic       rd_sel,
   input logic [7:0] rd_data,
   input logic [1:0] irq,
   input logic [5:0] cnt_mode,
   input logic       cfg_err
);
   logic ctl_wr;
   assign ctl_wr = wr_en && (wr_addr == 2'd3);

   assert_err_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_hi[7:6] == 2'b11) |=> cfg_err);

   assert_err_only_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> !cfg_err);

   assert_bad_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_hi[7:6] == 2'b00 && ctl_hi[5:4] != 2'b11)
      |=> (cfg_err && cnt_mode[2:0] == $past(cnt_mode[2:0])));

   assert_mode_ch0_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_hi[7:4] == 4'b0011) |=> (cnt_mode[2:0] == $past(ctl_hi[3:1])));

   assert_mode_ch2_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_hi[7:4] == 4'b1011)
      |=> (cnt_mode[5:3] == $past(ctl_hi[3:1]) && cnt_mode[2:0] == $past(cnt_mode[2:0])));

   assert_status_on_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[0] && !rd_sel) |-> (rd_data == FIRED_CODE));

   assert_status_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data == 8'h00) || (rd_data == FIRED_CODE));
endmodule

bind ivl_timer ivl_timer_chk #(.FIRED_CODE(FIRED_CODE)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .ctl_hi(wr_data[7:1]), .rd_sel(rd_sel), .rd_data(rd_data),
   .irq(irq), .cnt_mode(cnt_mode), .cfg_err(cfg_err));

// File: tb/ivl_timer_tb.sv
module ivl_timer_tb;
   localparam int CLK_PERIOD = 10;
   localparam longint BASE = 1193180;
   localparam longint CLKHZ = 1789770;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       rd_sel = 1'b0;
   logic [7:0] rd_data;
   logic [1:0] irq;
   logic [5:0] cnt_mode;
   logic       cfg_err;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   longint edge_k = 0;
   longint tick_cnt = 0;
   int m_cnt[2], m_rel[2], m_low[2], m_ph[2], m_run[2], m_fired[2], m_irq[2], m_mode[2];
   int m_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ivl_timer #(.CLK_HZ(CLKHZ), .BASE_HZ(BASE)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq), .cnt_mode(cnt_mode), .cfg_err(cfg_err));

   task automatic check(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Reference model, advanced on every rising edge (R1 tick timing)
   always @(posedge clk) begin
      if (!rst_n) begin
         edge_k = 0;
         m_err = 0;
         for (int i = 0; i < 2; i++) begin
            m_cnt[i] = 0; m_rel[i] = 0; m_low[i] = 0; m_ph[i] = 0;
            m_run[i] = 0; m_fired[i] = 0; m_irq[i] = 0; m_mode[i] = 0;
         end
      end else begin
         bit tk;
         edge_k++;
         tk = ((edge_k * BASE) / CLKHZ) != (((edge_k - 1) * BASE) / CLKHZ);
         if (tk) tick_cnt++;
         m_err = (wr_en && wr_addr == 3 && (wr_data[7:6] == 3 ||
                 (wr_data[7:6] != 1 && wr_data[5:4] != 3))) ? 1 : 0;
         for (int i = 0; i < 2; i++) begin
            bit ctl, dat, ld;
            ctl = wr_en && wr_addr == 3 && wr_data[7:6] == ((i == 0) ? 0 : 2) && wr_data[5:4] == 3;
            dat = wr_en && wr_addr == ((i == 0) ? 0 : 2);
            ld = 0;
            m_irq[i] = 0;
            if (ctl) begin
               m_mode[i] = wr_data[3:1];
               m_ph[i] = 0;
            end else if (dat) begin
               if (m_ph[i] == 0) begin
                  m_low[i] = wr_data;
                  m_ph[i] = 1;
               end else begin
                  m_rel[i] = wr_data * 256 + m_low[i];
                  m_cnt[i] = m_rel[i];
                  m_run[i] = 1; m_fired[i] = 0; m_ph[i] = 0; ld = 1;
               end
            end
            if (m_run[i] != 0 && tk && !ld) begin
               if (m_cnt[i] == 1) begin
                  m_cnt[i] = m_rel[i]; m_fired[i] = 1; m_irq[i] = 1;
               end else begin
                  m_cnt[i] = (m_cnt[i] + 65535) % 65536;
               end
            end
         end
         #2;
         if (!done) begin
            check("R11 irq ch0", irq[0], m_irq[0]);
            check("R11 irq ch2", irq[1], m_irq[1]);
            check("R3 R4 cfg_err", cfg_err, m_err);
            check("R5 R2 cnt_mode", cnt_mode, m_mode[1] * 8 + m_mode[0]);
            check("R10 status", rd_data, (m_fired[rd_sel] != 0) ? 32 : 0);
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_irq(input int idx, input longint t0, output longint ticks);
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!irq[idx] && n < 150000);
      ticks = tick_cnt - t0;
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R8 actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      longint t0, tk;
      int hits;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R12 irq", irq, 0);
      check("R12 cfg_err", cfg_err, 0);
      check("R12 cnt_mode", cnt_mode, 0);
      check("R12 status ch0", rd_data, 0);

      // R5: mode 2 on channel 0
      wr(2'd3, 8'h34);
      check("R5 mode ch0", cnt_mode[2:0], 2);
      // R6: low byte only, no counting
      wr(2'd0, 8'd3);
      hits = 0;
      repeat (20) begin @(negedge clk); if (irq[0]) hits++; end
      check("R6 no irq before high byte", hits, 0);
      check("R6 status before high byte", rd_data, 0);
      wr(2'd0, 8'd0);
      t0 = tick_cnt;
      wait_irq(0, t0, tk);
      check("R8 first period", tk, 3);
      check("R10 status after expiry", rd_data, 32);
      t0 = tick_cnt;
      wait_irq(0, t0, tk);
      check("R8 reload period", tk, 3);

      // R2: channel 2, mode 3; count 1 -> one irq per tick (R1)
      wr(2'd3, 8'hB6);
      check("R2 mode ch2", cnt_mode[5:3], 3);
      check("R2 ch0 mode kept", cnt_mode[2:0], 2);
      wr(2'd2, 8'd1);
      wr(2'd2, 8'd0);
      hits = 0;
      repeat (30) begin @(negedge clk); if (irq[1]) hits++; end
      check("R1 ticks in 30 clocks", hits, 20);

      // R3: read-back command
      wr(2'd3, 8'hF6);
      check("R3 err pulse", cfg_err, 1);
      check("R3 modes kept", cnt_mode, 6'o32);
      @(negedge clk);
      check("R3 err one cycle", cfg_err, 0);

      // R4: bad access mode keeps mode and byte phase
      wr(2'd0, 8'd5);
      wr(2'd3, 8'h1E);
      check("R4 err pulse", cfg_err, 1);
      check("R4 mode kept", cnt_mode[2:0], 2);
      wr(2'd0, 8'd0);
      check("R10 status cleared on load", rd_data, 0);
      t0 = tick_cnt;
      wait_irq(0, t0, tk);
      check("R4 phase kept period", tk, 5);

      // R7: control write restarts byte phase
      wr(2'd0, 8'd9);
      wr(2'd3, 8'h34);
      wr(2'd0, 8'd4);
      wr(2'd0, 8'd0);
      t0 = tick_cnt;
      wait_irq(0, t0, tk);
      check("R7 period after phase reset", tk, 4);

      // R2: counter 1 select ignored, no error
      wr(2'd3, 8'h76);
      check("R2 sel 01 no err", cfg_err, 0);
      check("R2 sel 01 modes kept", cnt_mode, 6'o32);

      // R9: count 0 on channel 2
      rd_sel = 1'b1;
      wr(2'd3, 8'hB4);
      wr(2'd2, 8'd0);
      wr(2'd2, 8'd0);
      check("R10 ch2 cleared", rd_data, 0);
      t0 = tick_cnt;
      wait_irq(1, t0, tk);
      check("R9 count zero period", tk, 65536);
      check("R10 ch2 status", rd_data, 32);

      repeat (4) @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule